// File: doc/BRIEF.md
# Dual-View Integer Register File

A register file of 64 general-purpose integer registers, each 64 bits wide. Two combinational read ports and one synchronous write port share the storage. Register 63 is not stored: it always reads as zero and silently drops any write addressed to it.

Every port has its own view select. The wide view reaches all 64 registers at full width. The narrow view reaches only registers 0 to 15, and only as 32-bit values. A narrow read returns the low half of the stored word, with the upper half forced to zero. A narrow write sign-extends its 32-bit operand to 64 bits before storing it. This lets 32-bit code share the same storage as 64-bit code without extra conversion steps.

Top module: `dual_view_regfile`

## Requirements
- R1: In the wide view (view select 0), a write with `wr_en` high stores all 64 bits of `wr_data` into register `wr_idx` (0 to 62). A later wide read of that index returns the stored value unchanged.
- R2: Register 63 reads as zero in the wide view on both ports. A write to index 63 in the wide view changes no register.
- R3: In the narrow view (view select 1), only index bits [3:0] select the register. Bits [5:4] are ignored, so narrow index 53 addresses register 5.
- R4: A narrow read returns `{32'h0, reg[31:0]}` for the selected register.
- R5: A narrow write stores `{{32{wr_data[31]}}, wr_data[31:0]}`. `wr_data[63:32]` has no effect on the stored value.
- R6: Both read ports return identical data when given the same index and view in the same cycle.
- R7: A write becomes visible on the rising clock edge that captures it. During the cycle in which the write is issued, reads of the same register return the old value.
- R8: While `rst_n` is low, registers 0 to 62 are cleared to zero, and reads return zero after any earlier contents.
- R9: With `wr_en` low, no register changes, whatever values the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the write is captured on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the storage |
| rd_a_idx | input | 6 | Read port A register index |
| rd_a_narrow | input | 1 | Read port A view: 0 wide, 1 narrow |
| rd_a_data | output | 64 | Read port A data (combinational) |
| rd_b_idx | input | 6 | Read port B register index |
| rd_b_narrow | input | 1 | Read port B view: 0 wide, 1 narrow |
| rd_b_data | output | 64 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 6 | Write register index |
| wr_narrow | input | 1 | Write view: 0 wide, 1 narrow |
| wr_data | input | 64 | Write data; in the narrow view only bits [31:0] are used |

## Verification
The stimulus has three parts:
- Every stored register is loaded with a distinct wide pattern that encodes its index. This exposes address aliasing and dropped bits. While each write is issued, the same register is read back, which separates a correct read-old-value result from an accidental bypass.
- Narrow writes use operands with bit 31 set and with bit 31 clear, each carrying non-zero upper data bits. Narrow reads use indices with bits [5:4] set. Together these separate correct sign extension, zero extension and index folding from truncation or use of the full index.
- Writes to index 63, writes with the enable low, and a reset in the middle of the run are each followed by reads on both ports. These show that the storage did or did not change as required.

// File: rtl/dual_view_regfile.sv
module dual_view_regfile #(
  parameter int NUM_REGS    = 64,
  parameter int XLEN        = 64,
  parameter int NARROW_W    = 32,
  parameter int NARROW_REGS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(NUM_REGS)-1:0] rd_a_idx,
  input  logic                        rd_a_narrow,
  output logic [XLEN-1:0]             rd_a_data,
  input  logic [$clog2(NUM_REGS)-1:0] rd_b_idx,
  input  logic                        rd_b_narrow,
  output logic [XLEN-1:0]             rd_b_data,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] wr_idx,
  input  logic                        wr_narrow,
  input  logic [XLEN-1:0]             wr_data
);
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int NIDX_W   = $clog2(NARROW_REGS);
  localparam int ZERO_REG = NUM_REGS - 1;
  localparam int EXT_W    = XLEN - NARROW_W;
  localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(ZERO_REG);

  logic [XLEN-1:0] regs [ZERO_REG];

  function automatic logic [IDX_W-1:0] fold(input logic [IDX_W-1:0] idx, input logic narrow);
    return narrow ? {{(IDX_W-NIDX_W){1'b0}}, idx[NIDX_W-1:0]} : idx;
  endfunction

  function automatic logic [XLEN-1:0] rd_view(input logic [IDX_W-1:0] idx, input logic narrow);
    logic [IDX_W-1:0] slot;
    logic [XLEN-1:0]  word;
    slot = fold(idx, narrow);
    word = (slot == ZERO_IDX) ? '0 : regs[slot];
    return narrow ? {{EXT_W{1'b0}}, word[NARROW_W-1:0]} : word;
  endfunction

  logic [IDX_W-1:0] wr_slot;
  logic [XLEN-1:0]  wr_val;

  assign wr_slot = fold(wr_idx, wr_narrow);
  assign wr_val  = wr_narrow ? {{EXT_W{wr_data[NARROW_W-1]}}, wr_data[NARROW_W-1:0]} : wr_data;

  for (genvar g = 0; g < ZERO_REG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 regs[g] <= '0;
      else if (wr_en && wr_slot == IDX_W'(g))     regs[g] <= wr_val;
    end
  end

  assign rd_a_data = rd_view(rd_a_idx, rd_a_narrow);
  assign rd_b_data = rd_view(rd_b_idx, rd_b_narrow);

  AST_ZERO_REG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_a_narrow && rd_a_idx == ZERO_IDX) |-> rd_a_data == '0); // R2

  AST_NARROW_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_narrow |-> rd_b_data[XLEN-1:NARROW_W] == '0); // R4

  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == rd_b_idx && rd_a_narrow == rd_b_narrow) |-> rd_a_data == rd_b_data); // R6

  AST_WIDE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && !wr_narrow && wr_idx != ZERO_IDX) && $past(rst_n) &&
     !rd_a_narrow && rd_a_idx == $past(wr_idx)) |-> rd_a_data == $past(wr_data)); // R1

  AST_NARROW_WRITE_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && wr_narrow) && $past(rst_n) && !rd_a_narrow &&
     rd_a_idx == {{(IDX_W-NIDX_W){1'b0}}, $past(wr_idx[NIDX_W-1:0])}) |->
    rd_a_data == {{EXT_W{$past(wr_data[NARROW_W-1])}}, $past(wr_data[NARROW_W-1:0])}); // R5

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en) && $past(rst_n) && $stable(rd_a_idx) && $stable(rd_a_narrow))
    |-> $stable(rd_a_data)); // R9
endmodule

// File: tb/tb_dual_view_regfile.sv
`timescale 1ns/100ps
module tb_dual_view_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic        rd_a_narrow = 1'b0, rd_b_narrow = 1'b0, wr_narrow = 1'b0, wr_en = 1'b0;
  logic [63:0] rd_a_data, rd_b_data, wr_data = '0;

  always #2 clk = ~clk;

  dual_view_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_narrow(rd_a_narrow), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_narrow(rd_b_narrow), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_narrow(wr_narrow), .wr_data(wr_data)
  );

  typedef struct { logic [63:0] exp_a; logic [63:0] exp_b; string tag; } item_t;
  item_t       sb[$];
  logic [63:0] mdl [64];
  int          n_chk = 0, n_fail = 0;
  event        cmp_ev;
  bit          done = 0;

  function automatic logic [63:0] model_rd(logic [5:0] idx, logic narrow);
    logic [5:0] s;
    s = narrow ? {2'b00, idx[3:0]} : idx;
    if (s == 6'd63) return '0;
    return narrow ? {32'h0, mdl[s][31:0]} : mdl[s];
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 64; i++) mdl[i] = '0;
  endtask

  task automatic op(input logic wen, input logic [5:0] widx, input logic wnar, input logic [63:0] wdat,
                    input logic [5:0] ra, input logic na, input logic [5:0] rb, input logic nb,
                    input string tag);
    item_t it;
    @(negedge clk);
    wr_en = wen; wr_idx = widx; wr_narrow = wnar; wr_data = wdat;
    rd_a_idx = ra; rd_a_narrow = na; rd_b_idx = rb; rd_b_narrow = nb;
    it.exp_a = model_rd(ra, na);
    it.exp_b = model_rd(rb, nb);
    it.tag = tag;
    sb.push_back(it);
    #0.5 -> cmp_ev;
    @(posedge clk);
    if (wen && rst_n) begin
      if (wnar) mdl[widx[3:0]] = {{32{wdat[31]}}, wdat[31:0]};
      else if (widx != 6'd63) mdl[widx] = wdat;
    end
  endtask

  task automatic rd(input logic [5:0] ra, input logic na, input logic [5:0] rb, input logic nb,
                    input string tag);
    op(1'b0, 6'd0, 1'b0, 64'h0, ra, na, rb, nb, tag);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(cmp_ev);
      #0.5;
      it = sb.pop_front();
      n_chk += 2;
      if (rd_a_data !== it.exp_a) begin
        n_fail++;
        $display("FAIL %s port A: actual %h expected %h", it.tag, rd_a_data, it.exp_a);
      end
      if (rd_b_data !== it.exp_b) begin
        n_fail++;
        $display("FAIL %s port B: actual %h expected %h", it.tag, rd_b_data, it.exp_b);
      end
    end
  end

  function automatic logic [63:0] pat(int i);
    return {8'(i), 8'hA5, 8'(~i), 8'h3C, 8'(i * 7), 8'h81, 8'(i + 1), 8'hF0};
  endfunction

  initial begin : driver
    clear_model();
    repeat (3) @(negedge clk);
    rd(6'd0, 1'b0, 6'd62, 1'b0, "R8 reset state");
    @(negedge clk) rst_n = 1'b1;
    rd(6'd5, 1'b1, 6'd63, 1'b0, "R8 after reset");

    for (int i = 0; i < 63; i++)
      op(1'b1, 6'(i), 1'b0, pat(i), 6'(i), 1'b0, 6'(i), 1'b0, "R7 no same-cycle bypass");
    for (int i = 0; i < 63; i++)
      rd(6'(i), 1'b0, 6'(62 - i), 1'b0, "R1 wide readback");

    op(1'b1, 6'd63, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 6'd63, 1'b0, 6'd62, 1'b0, "R2 write to r63");
    rd(6'd63, 1'b0, 6'd62, 1'b0, "R2 r63 reads zero, r62 intact");

    rd(6'd53, 1'b1, 6'd5, 1'b1, "R3 narrow index fold");
    rd(6'd5, 1'b1, 6'd5, 1'b0, "R4 narrow zero-extends");
    rd(6'd63, 1'b1, 6'd15, 1'b1, "R3 narrow 63 maps to r15");

    op(1'b1, 6'h22, 1'b1, 64'hDEAD_BEEF_8000_0001, 6'd2, 1'b0, 6'd34, 1'b0, "R7 narrow old value");
    rd(6'd2, 1'b0, 6'd34, 1'b0, "R5 negative sign-extend, R3 r34 untouched");
    op(1'b1, 6'd3, 1'b1, 64'hFFFF_FFFF_7FFF_0000, 6'd3, 1'b1, 6'd3, 1'b0, "R5 positive pre-write");
    rd(6'd3, 1'b0, 6'd19, 1'b1, "R5 positive sign-extend, R4 narrow view");

    op(1'b0, 6'd10, 1'b0, 64'h1234_5678_9ABC_DEF0, 6'd10, 1'b0, 6'd10, 1'b1, "R9 disabled write");
    op(1'b0, 6'd4, 1'b1, 64'h0BAD_F00D_0BAD_F00D, 6'd10, 1'b0, 6'd4, 1'b0, "R9 disabled write");
    rd(6'd10, 1'b0, 6'd4, 1'b0, "R9 contents unchanged");

    rd(6'd40, 1'b0, 6'd40, 1'b0, "R6 ports agree wide");
    rd(6'd41, 1'b1, 6'd41, 1'b1, "R6 ports agree narrow");

    @(negedge clk) rst_n = 1'b0;
    clear_model();
    rd(6'd40, 1'b0, 6'd2, 1'b1, "R8 mid-run reset");
    @(negedge clk) rst_n = 1'b1;
    rd(6'd0, 1'b0, 6'd62, 1'b0, "R8 cleared after reset");
    op(1'b1, 6'd62, 1'b0, 64'h0123_4567_89AB_CDEF, 6'd62, 1'b0, 6'd1, 1'b0, "R7 post-reset write");
    rd(6'd62, 1'b0, 6'd62, 1'b0, "R1 post-reset readback");

    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin : finisher
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule